// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block is the device end of a four-wire serial register port. A host drives a serial clock, a data line and an active-low strobe, and reads data back on a return line. The block has no chip select. Every rising edge of the serial clock while the strobe is high shifts one data bit into a 40-bit history. A single serial clock pulse taken with the strobe low carries the command bit. A 1 commits a write and a 0 starts a read. All three host lines are oversampled by the much faster system clock after a two-flop synchronizer.

A write frame sends 32 data bits and then 8 address bits, most significant bit first. When the command arrives, the low 8 bits of the history give the address and the 32 bits above them give the data. A read frame sends only the 8 address bits. The addressed word is then returned most significant bit first over the following 32 serial clock pulses. The register map holds three read/write configuration words whose values appear on output ports. It also holds a read-only switch word taken from an input port, a read-only version constant, and a reset-control word that can fire a timed reset pulse for the rest of the system.

Top module: `strobe_reg_slave`

## Requirements
- R1: Data bits are sampled on serial clock rising edges while the strobe is high, most significant bit first. Only the last 40 bits shifted before a command count, and any earlier surplus bits are ignored.
- R2: A command pulse with the data line at 1 writes history bits [39:8] to the register addressed by history bits [7:0].
- R3: A command pulse with the data line at 0 loads the addressed word into the return shifter on the serial clock falling edge that ends that pulse. Its most significant bit is on the return line before the next rising edge, and each later falling edge advances the shifter by one bit.
- R4: Addresses 0x00, 0x01 and 0x02 are read/write 32-bit words. They read back what was last written and drive the outputs mode_o, mux_o and hdmi_o.
- R5: Address 0x08 reads the sw_i input and address 0xFF reads the VERSION parameter. Writes to either address have no effect.
- R6: Writes to any address other than 0x00, 0x01, 0x02 and 0x80 change no register, and reads of unmapped addresses return zero.
- R7: Writing a word with bit 0 set to address 0x80 raises sys_rst_o for exactly RST_CYCLES system clocks. After the pulse the register at 0x80 reads zero. Writing a word with bit 0 clear stores it and produces no pulse.
- R8: After reset, all writable registers are zero, miso_o is low and sys_rst_o is low.
- R9: Serial clock pulses taken with the strobe high never change a register or an output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| stb_n_i | input | 1 | Active-low command strobe, idle high |
| mosi_i | input | 1 | Serial data from the host, idle low |
| miso_o | output | 1 | Serial read data to the host |
| sw_i | input | 32 | Switch word returned at address 0x08 |
| mode_o | output | 32 | Contents of the register at 0x00 |
| mux_o | output | 32 | Contents of the register at 0x01 |
| hdmi_o | output | 32 | Contents of the register at 0x02 |
| sys_rst_o | output | 1 | Timed reset pulse for the system |

## Verification
The hardest case to reach is the history window. The bench must show that only the final 40 bits before a command are decoded and that long runs of bits without a command commit nothing. To cover this, the bench clocks surplus leading bits ahead of a full write frame, and separately clocks a complete frame with no command pulse. It then reads back the affected words over the serial port and also watches the output ports. The reset pulse is measured by a system-clock counter in the bench, so its width is checked cycle-exactly rather than only its presence.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_MODE = 8'h00;
  localparam logic [ADDR_W-1:0] A_MUX  = 8'h01;
  localparam logic [ADDR_W-1:0] A_HDMI = 8'h02;
  localparam logic [ADDR_W-1:0] A_SW   = 8'h08;
  localparam logic [ADDR_W-1:0] A_RST  = 8'h80;
  localparam logic [ADDR_W-1:0] A_VER  = 8'hFF;

  // true when a write to this address may change state
  function automatic logic addr_writable(input logic [ADDR_W-1:0] a);
    return (a == A_MODE) || (a == A_MUX) || (a == A_HDMI) || (a == A_RST);
  endfunction

  // a write to the reset word with bit 0 set requests a pulse
  function automatic logic pulse_request(input logic [ADDR_W-1:0] a, input logic b0);
    return (a == A_RST) && b0;
  endfunction
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= INIT;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= INIT;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int HIST_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              stb_s,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              wr_ev,
  output logic              rd_ev,
  output logic              tx_load,
  output logic              tx_shift,
  output logic [HIST_W-1:0] hist
);
  logic sclk_q;
  logic rd_pend;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign wr_ev     = sclk_rise & ~stb_s & mosi_s;
  assign rd_ev     = sclk_rise & ~stb_s & ~mosi_s;
  assign tx_load   = sclk_fall & rd_pend;
  assign tx_shift  = sclk_fall & ~rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      hist    <= '0;
      rd_pend <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      if (sclk_rise && stb_s) hist <= {hist[HIST_W-2:0], mosi_s};
      if (rd_ev)        rd_pend <= 1'b1;
      else if (tx_load) rd_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
  import srs_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] VERSION    = 32'h0001_0000,
  parameter int          RST_CYCLES = 16,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic [DATA_W-1:0] hdmi_o,
  output logic [DATA_W-1:0] rst_word,
  output logic              sys_rst_o
);
  logic [CNT_W-1:0] rst_cnt;
  logic             wr_ok;

  assign wr_ok     = wr_ev && addr_writable(addr);
  assign sys_rst_o = (rst_cnt != '0);

  always_comb begin
    case (addr)
      A_MODE:  rdata = mode_o;
      A_MUX:   rdata = mux_o;
      A_HDMI:  rdata = hdmi_o;
      A_SW:    rdata = sw_i;
      A_RST:   rdata = rst_word;
      A_VER:   rdata = DATA_W'(VERSION);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o   <= '0;
      mux_o    <= '0;
      hdmi_o   <= '0;
      rst_word <= '0;
      rst_cnt  <= '0;
    end else begin
      if (wr_ok && addr == A_MODE) mode_o <= wdata;
      if (wr_ok && addr == A_MUX)  mux_o  <= wdata;
      if (wr_ok && addr == A_HDMI) hdmi_o <= wdata;

      if (wr_ok && addr == A_RST)   rst_word <= wdata;
      else if (rst_cnt == CNT_W'(1)) rst_word <= '0;

      if (wr_ok && pulse_request(addr, wdata[0])) rst_cnt <= CNT_W'(RST_CYCLES);
      else if (rst_cnt != '0)                     rst_cnt <= rst_cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/srs_txshift.sv
module srs_txshift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] ldata,
  output logic              miso_o
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= ldata;
    else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign miso_o = sh[DATA_W-1];
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import srs_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] VERSION     = 32'h0001_0000,
  parameter int          RST_CYCLES  = 16,
  localparam int HIST_W = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              stb_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic [DATA_W-1:0] hdmi_o,
  output logic              sys_rst_o
);
  logic              sclk_s, stb_s, mosi_s;
  logic              sclk_rise, sclk_fall;
  logic              wr_ev, rd_ev, tx_load, tx_shift;
  logic [HIST_W-1:0] hist;
  logic [DATA_W-1:0] rdata, rst_word;

  srs_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, stb_n_i, mosi_i}),
    .q({sclk_s, stb_s, mosi_s})
  );

  srs_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .mosi_s(mosi_s), .stb_s(stb_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .wr_ev(wr_ev), .rd_ev(rd_ev),
    .tx_load(tx_load), .tx_shift(tx_shift),
    .hist(hist)
  );

  srs_regfile #(.DATA_W(DATA_W), .VERSION(VERSION), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_ev(wr_ev),
    .addr(hist[ADDR_W-1:0]),
    .wdata(hist[HIST_W-1:ADDR_W]),
    .sw_i(sw_i),
    .rdata(rdata),
    .mode_o(mode_o), .mux_o(mux_o), .hdmi_o(hdmi_o),
    .rst_word(rst_word),
    .sys_rst_o(sys_rst_o)
  );

  srs_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(tx_load), .shift(tx_shift),
    .ldata(rdata),
    .miso_o(miso_o)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int DATA_W = 32,
  parameter int HIST_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              stb_s,
  input logic              wr_ev,
  input logic              tx_load,
  input logic              tx_shift,
  input logic [HIST_W-1:0] hist,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] rst_word,
  input logic              miso_o,
  input logic              sys_rst_o
);
  // R1
  hist_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hist) |-> ($past(sclk_rise) && $past(stb_s)));

  // R9
  mode_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> $past(wr_ev));

  // R3
  miso_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_o) |-> ($past(tx_load) || $past(tx_shift)));

  // R7
  pulse_starts_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(wr_ev));

  // R7
  pulse_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sys_rst_o) && !$past(wr_ev)) |-> (rst_word == '0));
endmodule

bind strobe_reg_slave srs_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sclk_rise(sclk_rise), .stb_s(stb_s),
  .wr_ev(wr_ev), .tx_load(tx_load), .tx_shift(tx_shift),
  .hist(hist), .mode_o(mode_o), .rst_word(rst_word),
  .miso_o(miso_o), .sys_rst_o(sys_rst_o)
);

// File: tb/strobe_reg_slave_bench.sv
module strobe_reg_slave_bench;
  localparam int          HALF  = 6;
  localparam int          RSTC  = 5;
  localparam logic [31:0] VER   = 32'hC0DE_0102;
  localparam logic [31:0] SWV   = 32'h5A5A_C3C3;

  // {addr, write data, expected read-back}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R4
    {8'h01, 32'h1234_5678, 32'h1234_5678},  // R4
    {8'h02, 32'hFFFF_0001, 32'hFFFF_0001},  // R4
    {8'h08, 32'h0BAD_F00D, SWV},            // R5
    {8'hFF, 32'h1111_1111, VER},            // R5
    {8'h03, 32'h7777_7777, 32'h0},          // R6
    {8'h40, 32'h8888_8888, 32'h0},          // R6
    {8'h00, 32'h0000_0001, 32'h0000_0001}   // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, stb_n = 1'b1, mosi = 1'b0;
  logic [31:0] sw = SWV;
  logic miso, sys_rst;
  logic [31:0] mode_w, mux_w, hdmi_w;
  int nchk = 0, nfail = 0, rst_hi = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strobe_reg_slave #(.VERSION(VER), .RST_CYCLES(RSTC)) u_strobe_reg_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .stb_n_i(stb_n), .mosi_i(mosi),
    .miso_o(miso), .sw_i(sw), .mode_o(mode_w), .mux_o(mux_w), .hdmi_o(hdmi_w),
    .sys_rst_o(sys_rst)
  );

  always @(negedge clk) if (sys_rst) rst_hi++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b; waitc(HALF);
    sclk = 1'b1; waitc(HALF);
    sclk = 1'b0;
  endtask

  task automatic cmd_pulse(input logic b);
    mosi = b; stb_n = 1'b0; waitc(HALF);
    sclk = 1'b1; waitc(HALF);
    sclk = 1'b0; waitc(HALF);
    stb_n = 1'b1; mosi = 1'b0; waitc(HALF);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) send_bit(d[i]);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    cmd_pulse(1'b1);
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    cmd_pulse(1'b0);
    d = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b1; waitc(HALF);
      d = {d[30:0], miso};
      sclk = 1'b0; waitc(HALF);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired got %0d expected 0", 1);
      report();
    end
  end

  initial begin
    logic [31:0] rd;
    waitc(4); rst_n = 1'b1; waitc(4);

    // R8: reset state
    check("R8 mode_o", mode_w, 32'h0);
    check("R8 mux_o", mux_w, 32'h0);
    check("R8 hdmi_o", hdmi_w, 32'h0);
    check("R8 miso_o", {31'h0, miso}, 32'h0);
    check("R8 sys_rst_o", {31'h0, sys_rst}, 32'h0);
    host_read(8'h80, rd);
    check("R8 reset word", rd, 32'h0);

    // vector table: write then read back
    foreach (VEC[k]) begin
      host_write(VEC[k][71:64], VEC[k][63:32]);
      host_read(VEC[k][71:64], rd);
      check($sformatf("R2/R3/R4/R5/R6 vec %0d", k), rd, VEC[k][31:0]);
    end

    // R4: output ports follow the written words; R6: unmapped writes left them intact
    check("R4 mode_o", mode_w, 32'h0000_0001);
    check("R4 mux_o", mux_w, 32'h1234_5678);
    check("R6 hdmi_o", hdmi_w, 32'hFFFF_0001);

    // R1: surplus leading bits are ignored
    for (int i = 0; i < 16; i++) send_bit(i[0]);
    host_write(8'h01, 32'hCAFE_BABE);
    host_read(8'h01, rd);
    check("R1 surplus bits", rd, 32'hCAFE_BABE);

    // R9: a full frame without command commits nothing
    for (int i = 31; i >= 0; i--) send_bit(~i[1]);
    for (int i = 7; i >= 0; i--) send_bit(1'b0);
    waitc(4 * HALF);
    check("R9 mode_o", mode_w, 32'h0000_0001);
    host_read(8'h02, rd);
    check("R9 hdmi read", rd, 32'hFFFF_0001);

    // R7: reset pulse width and self-clear
    rst_hi = 0;
    host_write(8'h80, 32'h0000_0001);
    waitc(4 * RSTC);
    check("R7 pulse width", rst_hi, RSTC);
    host_read(8'h80, rd);
    check("R7 self clear", rd, 32'h0);

    // R7: bit 0 clear stores without a pulse
    rst_hi = 0;
    host_write(8'h80, 32'h0000_0002);
    waitc(4 * RSTC);
    check("R7 no pulse", rst_hi, 0);
    host_read(8'h80, rd);
    check("R7 stored word", rd, 32'h0000_0002);

    done = 1;
    report();
  end
endmodule